// File: doc/BRIEF.md
# Four-Channel MIDI Serial Receiver

This block receives four asynchronous MIDI serial lines at the same time. The start bits on the four lines arrive at unrelated moments. One counter produces a quarter-bit tick, and all four channels share it. Each channel first passes its raw line through a two-flop synchronizer. It then watches for the falling edge that opens a character. Once that edge is seen, the channel counts shared ticks so that it samples near the middle of every bit. From those samples it builds an 8-bit byte.

Every channel has its own outputs: a one-cycle valid strobe, a data bus that holds the last good byte, and a one-cycle framing-error strobe. Message parsing and buffering are left to whatever logic consumes these strobes. The tick divider is derived from the system clock frequency and the MIDI line rate, so the same code serves any clock that is a reasonable multiple of 125 kHz.

Top module: `midi4_rx`

## Requirements
- R1: While `rst_n` is low, and on the cycle after each reset edge, every valid and framing-error strobe is 0 and every data bus is 0.
- R2: The quarter-bit period is CLK_HZ/(BAUD*4) clock cycles. A character (start bit, eight data bits, stop bit) spans 40 quarter-bit periods.
- R3: Each channel starts reception on a high-to-low transition of its own line. The four channels work independently, including when their characters overlap in time.
- R4: Data bits are taken least-significant first. When the stop bit is high, the channel raises its valid strobe for one cycle. In that same cycle its 8-bit slice of `byte_o` (channel c at bits 8c+7..8c) shows the byte. The slice changes on no other cycle.
- R5: A channel's valid or framing-error strobe appears no earlier than 36 and no later than 40 quarter-bit periods after the start edge reaches the pin.
- R6: If the line is high again when the start bit is sampled at mid-bit, the channel drops the reception and produces neither strobe.
- R7: While a channel is receiving a character, falling edges on its line do not restart it. Characters that follow each other without gaps are all received.
- R8: When the stop-bit sample is low, the channel raises its framing-error strobe for one cycle instead of the valid strobe, and its data slice keeps its previous value.
- R9: After a framing error, a channel accepts a new start only after its line has been seen high. A byte sent after the line returns high is received normally.
- R10: On any channel, the valid and framing-error strobes are never high together, and each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_i | input | CH | Raw serial lines, one per channel, idle high |
| byte_vld_o | output | CH | One-cycle strobe per channel: a good byte has arrived |
| byte_o | output | CH*DW | Last good byte of each channel, channel c in slice c*DW +: DW |
| frame_err_o | output | CH | One-cycle strobe per channel: stop bit was sampled low |

## Verification
A channel's result cannot be predicted to the exact cycle. Where the start edge lands relative to the shared tick shifts the stop-bit sample by up to one quarter bit, and the synchronizer adds two to three cycles on top of that. Each expected item is therefore queued with the cycle of its start edge. When a strobe appears, the monitor requires the elapsed time to fall between 36 and 40 quarter-bit periods, which is where R5 places the result. Outcomes that must not occur, such as a rejected glitch or a line held low after a framing error, are checked by waiting well past that window. The bench then confirms that no strobe arrived and that every queue is empty.

// File: rtl/midi4_rx.sv
module midi4_rx #(
  parameter int CLK_HZ = 200_000_000,
  parameter int BAUD   = 31_250,
  parameter int CH     = 4,
  parameter int DW     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CH-1:0]    rx_i,
  output logic [CH-1:0]    byte_vld_o,
  output logic [CH*DW-1:0] byte_o,
  output logic [CH-1:0]    frame_err_o
);

  localparam int QDIV = (CLK_HZ / (BAUD * 4)) < 1 ? 1 : CLK_HZ / (BAUD * 4);
  localparam int QW   = QDIV > 1 ? $clog2(QDIV) : 1;
  localparam int BW   = $clog2(DW + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_STOP, S_HOLD} st_t;

  logic [QW-1:0] qcnt;
  logic          tick;

  assign tick = (qcnt == QW'(QDIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || tick) qcnt <= '0;
    else                qcnt <= qcnt + 1'b1;
  end

  for (genvar c = 0; c < CH; c++) begin : g_ch
    logic [2:0]    sync;
    st_t           st;
    logic [1:0]    ph;
    logic [BW-1:0] nbits;
    logic [DW-1:0] sh, dout;
    logic          vld, ferr;
    logic          line, fall;

    assign line = sync[1];
    assign fall = sync[2] & ~sync[1];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sync  <= '1;
        st    <= S_IDLE;
        ph    <= '0;
        nbits <= '0;
        sh    <= '0;
        dout  <= '0;
        vld   <= 1'b0;
        ferr  <= 1'b0;
      end else begin
        sync <= {sync[1:0], rx_i[c]};
        vld  <= 1'b0;
        ferr <= 1'b0;
        case (st)
          S_IDLE:
            if (fall) begin
              st <= S_START;
              ph <= '0;
            end
          S_START:
            if (tick) begin
              ph <= ph + 1'b1;
              if (ph == 2'd1) begin
                ph    <= '0;
                nbits <= '0;
                st    <= line ? S_IDLE : S_DATA;
              end
            end
          S_DATA:
            if (tick) begin
              ph <= ph + 1'b1;
              if (ph == 2'd3) begin
                sh    <= {line, sh[DW-1:1]};
                nbits <= nbits + 1'b1;
                if (nbits == BW'(DW - 1)) st <= S_STOP;
              end
            end
          S_STOP:
            if (tick) begin
              ph <= ph + 1'b1;
              if (ph == 2'd3) begin
                if (line) begin
                  vld  <= 1'b1;
                  dout <= sh;
                  st   <= S_IDLE;
                end else begin
                  ferr <= 1'b1;
                  st   <= S_HOLD;
                end
              end
            end
          S_HOLD:
            if (line) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end

    assign byte_vld_o[c]           = vld;
    assign frame_err_o[c]          = ferr;
    assign byte_o[c*DW +: DW]      = dout;
  end

endmodule

// File: rtl/midi4_rx_chk.sv
module midi4_rx_chk #(
  parameter int CH = 4,
  parameter int DW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CH-1:0]    byte_vld_o,
  input logic [CH*DW-1:0] byte_o,
  input logic [CH-1:0]    frame_err_o
);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (byte_vld_o == '0 && frame_err_o == '0 && byte_o == '0));

  for (genvar c = 0; c < CH; c++) begin : g_chk
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(byte_vld_o[c] && frame_err_o[c]));
    a_r10_vld_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld_o[c] |=> !byte_vld_o[c]);
    a_r10_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err_o[c] |=> !frame_err_o[c]);
    a_r4_data_moves_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(byte_o[c*DW +: DW]) |-> byte_vld_o[c]);
    a_r8_err_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
      frame_err_o[c] |-> $stable(byte_o[c*DW +: DW]));
  end

endmodule

bind midi4_rx midi4_rx_chk #(.CH(CH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_vld_o(byte_vld_o),
  .byte_o(byte_o), .frame_err_o(frame_err_o)
);

// File: tb/midi4_rx_bench.sv
module midi4_rx_bench;
  localparam int CLK_HZ = 1_000_000;
  localparam int BAUD   = 31_250;
  localparam int Q      = CLK_HZ / (BAUD * 4);
  localparam int BITC   = 4 * Q;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  rx = '1;
  logic [3:0]  vld, ferr;
  logic [31:0] dbus;

  int     total = 0, bad = 0;
  longint cyc = 0;
  int     got [4];
  int     errs [4];
  logic [7:0] last [4];
  logic [8:0] expq [4][$];
  longint     tq [4][$];

  midi4_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .CH(4), .DW(8)) u_midi4_rx (
    .clk(clk), .rst_n(rst_n), .rx_i(rx),
    .byte_vld_o(vld), .byte_o(dbus), .frame_err_o(ferr));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int c, input logic [7:0] b, input logic stop);
    @(negedge clk);
    rx[c] = 1'b0;
    expq[c].push_back({~stop, b});
    tq[c].push_back(cyc);
    repeat (BITC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx[c] = b[i];
      repeat (BITC) @(negedge clk);
    end
    rx[c] = stop;
    repeat (BITC) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < 4; c++) begin
        if (vld[c] || ferr[c]) begin
          logic [8:0] e;
          longint t0, dt;
          check(!(vld[c] && ferr[c]), "R10 both strobes", {vld[c], ferr[c]}, 0);
          if (expq[c].size() == 0) begin
            check(0, "R6 unexpected strobe", c, -1);
          end else begin
            e  = expq[c].pop_front();
            t0 = tq[c].pop_front();
            dt = cyc - t0;
            check(dt >= 36*Q && dt <= 40*Q, "R5 R2 result timing", dt, 38*Q);
            if (e[8]) begin
              check(ferr[c] === 1'b1, "R8 framing error expected", ferr[c], 1);
              check(dbus[c*8 +: 8] == last[c], "R8 data held", dbus[c*8 +: 8], last[c]);
              errs[c]++;
            end else begin
              check(vld[c] === 1'b1, "R4 valid expected", vld[c], 1);
              check(dbus[c*8 +: 8] == e[7:0], "R4 data LSB first", dbus[c*8 +: 8], e[7:0]);
              last[c] = e[7:0];
              got[c]++;
            end
          end
        end
      end
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) begin got[c] = 0; errs[c] = 0; last[c] = 8'h00; end
    repeat (5) @(negedge clk);
    check(vld == 4'b0,  "R1 valid in reset", vld, 0);
    check(ferr == 4'b0, "R1 error in reset", ferr, 0);
    check(dbus == 32'b0, "R1 data in reset", dbus, 0);
    rst_n = 1;
    repeat (10) @(negedge clk);

    // single byte
    send(0, 8'hA5, 1'b1);
    repeat (2*BITC) @(negedge clk);
    check(got[0] == 1, "R4 single byte", got[0], 1);

    // R3: four overlapping channels with staggered starts
    fork
      send(0, 8'h00, 1'b1);
      begin repeat (3)  @(negedge clk); send(1, 8'hFF, 1'b1); end
      begin repeat (11) @(negedge clk); send(2, 8'h5A, 1'b1); end
      begin repeat (27) @(negedge clk); send(3, 8'h81, 1'b1); end
    join
    repeat (2*BITC) @(negedge clk);
    check(got[0] == 2, "R3 channel 0 count", got[0], 2);
    check(got[1] == 1, "R3 channel 1 count", got[1], 1);
    check(got[2] == 1, "R3 channel 2 count", got[2], 1);
    check(got[3] == 1, "R3 channel 3 count", got[3], 1);

    // R7: back-to-back bytes full of falling edges
    send(1, 8'h55, 1'b1);
    send(1, 8'hAA, 1'b1);
    send(1, 8'h33, 1'b1);
    repeat (2*BITC) @(negedge clk);
    check(got[1] == 4, "R7 back-to-back count", got[1], 4);

    // R6: short low glitch
    @(negedge clk); rx[2] = 1'b0;
    repeat (Q - 2) @(negedge clk); rx[2] = 1'b1;
    repeat (12*BITC) @(negedge clk);
    check(got[2] == 1 && errs[2] == 0, "R6 glitch ignored", got[2] + errs[2], 1);

    // R8 / R9: bad stop bit, line held low, then recovery
    send(3, 8'h3C, 1'b0);
    repeat (3*BITC) @(negedge clk);
    check(errs[3] == 1, "R8 error count", errs[3], 1);
    check(got[3] == 1, "R9 no byte while held low", got[3], 1);
    rx[3] = 1'b1;
    repeat (2*BITC) @(negedge clk);
    send(3, 8'hC3, 1'b1);
    repeat (2*BITC) @(negedge clk);
    check(got[3] == 2, "R9 rearm after high", got[3], 2);
    check(dbus[31:24] == 8'hC3, "R9 data after rearm", dbus[31:24], 8'hC3);

    for (int c = 0; c < 4; c++)
      check(expq[c].size() == 0, "R6 scoreboard drained", expq[c].size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100_000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule